// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and a slower memory port. The processor posts byte-granular stores of up to one 8-byte word and continues without waiting for memory. Each store is either merged into a buffer entry that already holds its 64-byte line, or it takes a new entry. Each entry keeps a line tag, the line's data bytes and a per-byte valid mask. Entries leave in arrival order as single masked full-line writes, so a run of stores to one line costs one memory transaction instead of one per store.

The head entry is sent downstream when a newer entry is queued behind it, when its mask is complete, or when flush is held. Once the head is offered to memory it is frozen. A store to the same line then opens a fresh entry. When every entry is occupied and a store cannot merge, the store port stalls. The stall is lifted in the same cycle that an entry leaves. The downstream ready input models a blocked port, and stores keep accumulating while it is low.

Top module: `wr_coalesce_buf`

## Requirements
- R1: After reset the block is empty. `empty_o` is 1, `mem_valid_o` is 0 and `st_ready_o` is 1. `empty_o` is 1 exactly when no entry is occupied.
- R2: A store whose line matches an occupied entry that is not being drained is merged into that entry. No entry is allocated, and this also holds when the buffer is full.
- R3: Where a newer store writes bytes an entry already holds, the newer bytes replace the older ones. The entry's mask is the OR of all merged byte enables.
- R4: Eight stores with all byte enables set, covering words 0 to 7 of one line, produce exactly one memory transaction whose mask is all ones.
- R5: With all entries occupied, a store to a line held by no mergeable entry sees `st_ready_o` low, unless an entry leaves in that cycle.
- R6: If a drain handshake (`mem_valid_o` and `mem_ready_i` both high) happens in the same cycle, a store to a new line is accepted even though every entry is occupied.
- R7: Transactions leave in the order their entries were allocated.
- R8: A single entry with an incomplete mask is held while `flush_i` is low. The head is offered once another entry exists behind it, once its mask is complete, or while `flush_i` is high.
- R9: From the cycle `mem_valid_o` rises until the handshake, `mem_addr_o`, `mem_data_o` and `mem_mask_o` stay constant. A store to the line being drained does not merge into it; it allocates a new entry, or stalls if the buffer is full.
- R10: Holding `flush_i` high with `mem_ready_i` high drains every entry and raises `empty_o`.
- R11: Store format and line format:
  - `st_waddr_i` is a word address. Bits [2:0] select the word in the line, and the upper bits form the line tag that appears on `mem_addr_o`.
  - Store byte j (`st_data_i[8j+7:8j]`, enabled by `st_be_i[j]`) lands in line byte 8*word+j.
  - Line byte k appears at `mem_data_o[8k+7:8k]` and `mem_mask_o[k]`.
  - Bytes that were never written are sent as zero.
- R12: While `mem_ready_i` is low, up to ENTRIES stores to distinct lines are accepted without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_waddr_i | input | ADDR_W-3 (29) | Store word address |
| st_data_i | input | 64 | Store data, byte j in bits [8j+7:8j] |
| st_be_i | input | 8 | Store byte enables |
| st_ready_o | output | 1 | Store accepted this cycle; low means stall |
| mem_valid_o | output | 1 | Line write offered |
| mem_ready_i | input | 1 | Memory port accepts the write; low models a blocked port |
| mem_addr_o | output | ADDR_W-6 (26) | Line tag of the write |
| mem_data_o | output | 512 | Line data |
| mem_mask_o | output | 64 | Per-byte write mask |
| flush_i | input | 1 | Force all entries to drain |
| empty_o | output | 1 | No entry occupied |

## Verification
Suppose an entry's mask or data register merges the wrong bytes, or misses a merge. That error stays hidden until the entry leaves, and then shows as a wrong byte in the memory image. So every test ends with a full flush and a byte-by-byte comparison against a model memory written by accepted stores. A wrong head or tail pointer shows as transactions out of order, or as a lost or duplicated line within one drain. A wrong occupancy count shows either as a stall with room to spare or as an overwritten entry, both visible on the very store that hits the boundary.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;
  typedef enum logic {DRN_IDLE, DRN_BUSY} drn_state_e;
endpackage

// File: rtl/wcb_lookup.sv
`timescale 1ns/1ps
module wcb_lookup #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 26,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [ENTRIES-1:0]            lock_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]              probe_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld_i[g] && !lock_i[g] && (tag_i[g] == probe_i);
  end

  // at most one unlocked entry holds a given line
  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (eq[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/wcb_entry.sv
`timescale 1ns/1ps
module wcb_entry #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned TAG_W      = 26,
  localparam int unsigned WORDS     = LINE_BYTES / WORD_BYTES,
  localparam int unsigned WRD_W     = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    merge_i,
  input  logic                    clr_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [WRD_W-1:0]        word_i,
  input  logic [WORD_BYTES*8-1:0] data_i,
  input  logic [WORD_BYTES-1:0]   be_i,
  output logic                    vld_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_BYTES*8-1:0] data_o,
  output logic [LINE_BYTES-1:0]   mask_o
);
  // alloc beats clr: a freed slot may be refilled in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      tag_o  <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else if (alloc_i || merge_i) begin
      vld_o <= 1'b1;
      if (alloc_i) tag_o <= tag_i;
      for (int k = 0; k < LINE_BYTES; k++) begin
        if (WRD_W'(k / WORD_BYTES) == word_i && be_i[k % WORD_BYTES]) begin
          data_o[8*k +: 8] <= data_i[8*(k % WORD_BYTES) +: 8];
          mask_o[k]        <= 1'b1;
        end else if (alloc_i) begin
          data_o[8*k +: 8] <= 8'h00;
          mask_o[k]        <= 1'b0;
        end
      end
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wcb_drain_ctrl.sv
`timescale 1ns/1ps
module wcb_drain_ctrl #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             head_full_i,
  input  logic             flush_i,
  input  logic             mem_ready_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             pop_o
);
  import wcb_pkg::*;

  drn_state_e       st_q;
  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W:0]   tail_sum;
  logic             start;

  assign busy_o   = (st_q == DRN_BUSY);
  assign pop_o    = busy_o && mem_ready_i;
  assign head_o   = head_q;
  assign cnt_o    = cnt_q;
  assign tail_sum = {1'b0, head_q} + (IDX_W+1)'(cnt_q);
  assign tail_o   = (tail_sum >= (IDX_W+1)'(ENTRIES)) ?
                    IDX_W'(tail_sum - (IDX_W+1)'(ENTRIES)) : IDX_W'(tail_sum);
  // hold a lone partial line so later stores can still merge
  assign start    = !busy_o && (cnt_q != '0) &&
                    ((cnt_q > CNT_W'(1)) || head_full_i || flush_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DRN_IDLE;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_o);
      if (pop_o)
        head_q <= (head_q == IDX_W'(ENTRIES - 1)) ? '0 : head_q + IDX_W'(1);
      if (pop_o)      st_q <= DRN_IDLE;
      else if (start) st_q <= DRN_BUSY;
    end
  end
endmodule

// File: rtl/wr_coalesce_buf.sv
`timescale 1ns/1ps
module wr_coalesce_buf #(
  parameter int unsigned ENTRIES    = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned WOFF_W    = $clog2(WORD_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W,
  localparam int unsigned WA_W      = ADDR_W - WOFF_W,
  localparam int unsigned WRD_W     = OFF_W - WOFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  input  logic [WA_W-1:0]         st_waddr_i,
  input  logic [WORD_BYTES*8-1:0] st_data_i,
  input  logic [WORD_BYTES-1:0]   st_be_i,
  output logic                    st_ready_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [TAG_W-1:0]        mem_addr_o,
  output logic [LINE_BYTES*8-1:0] mem_data_o,
  output logic [LINE_BYTES-1:0]   mem_mask_o,
  input  logic                    flush_i,
  output logic                    empty_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]                   ent_vld, lock;
  logic [ENTRIES-1:0][TAG_W-1:0]        ent_tag;
  logic [ENTRIES-1:0][LINE_BYTES*8-1:0] ent_data;
  logic [ENTRIES-1:0][LINE_BYTES-1:0]   ent_mask;

  logic [TAG_W-1:0] st_tag;
  logic [WRD_W-1:0] st_word;
  logic             hit, merge, push, pop, busy;
  logic [IDX_W-1:0] hit_idx, head, tail;
  logic [CNT_W-1:0] occ_cnt;

  assign st_tag  = st_waddr_i[WA_W-1:WRD_W];
  assign st_word = st_waddr_i[WRD_W-1:0];

  wcb_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lookup (
    .vld_i(ent_vld), .lock_i(lock), .tag_i(ent_tag), .probe_i(st_tag),
    .hit_o(hit), .idx_o(hit_idx)
  );

  assign st_ready_o = hit || (occ_cnt != CNT_W'(ENTRIES)) || pop;
  assign merge      = st_valid_i && hit;
  assign push       = st_valid_i && st_ready_o && !hit;

  wcb_drain_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk_i, .rst_ni, .push_i(push), .head_full_i(&ent_mask[head]),
    .flush_i, .mem_ready_i, .head_o(head), .tail_o(tail), .cnt_o(occ_cnt),
    .busy_o(busy), .pop_o(pop)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign lock[g] = busy && (head == IDX_W'(g));
    wcb_entry #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .TAG_W(TAG_W)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(push && (tail == IDX_W'(g))),
      .merge_i(merge && (hit_idx == IDX_W'(g))),
      .clr_i(pop && (head == IDX_W'(g))),
      .tag_i(st_tag), .word_i(st_word), .data_i(st_data_i), .be_i(st_be_i),
      .vld_o(ent_vld[g]), .tag_o(ent_tag[g]), .data_o(ent_data[g]),
      .mask_o(ent_mask[g])
    );
  end

  assign mem_valid_o = busy;
  assign mem_addr_o  = ent_tag[head];
  assign mem_data_o  = ent_data[head];
  assign mem_mask_o  = ent_mask[head];
  assign empty_o     = (occ_cnt == '0);
endmodule

// File: rtl/wcb_checker.sv
`timescale 1ns/1ps
module wcb_checker #(
  parameter int unsigned ENTRIES    = 4,
  parameter int unsigned TAG_W      = 26,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned CNT_W     = $clog2(ENTRIES + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    st_valid_i,
  input logic                    st_ready_o,
  input logic                    mem_valid_o,
  input logic                    mem_ready_i,
  input logic [TAG_W-1:0]        mem_addr_o,
  input logic [LINE_BYTES*8-1:0] mem_data_o,
  input logic [LINE_BYTES-1:0]   mem_mask_o,
  input logic                    empty_o,
  input logic [CNT_W-1:0]        occ_cnt
);
  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_cnt <= CNT_W'(ENTRIES));

  p_stall_only_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> occ_cnt == CNT_W'(ENTRIES));

  p_free_accepts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && occ_cnt < CNT_W'(ENTRIES)) |-> st_ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_data_o) && $stable(mem_mask_o)));

  p_empty_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !mem_valid_o);

  p_mask_nonzero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_mask_o != '0);

  p_pop_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !st_valid_i) |=> occ_cnt == $past(occ_cnt) - CNT_W'(1));
endmodule

bind wr_coalesce_buf wcb_checker #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
) u_wcb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_valid_i(st_valid_i), .st_ready_o(st_ready_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
  .mem_data_o(mem_data_o), .mem_mask_o(mem_mask_o), .empty_o(empty_o),
  .occ_cnt(occ_cnt)
);

// File: tb/wr_coalesce_buf_bench.sv
`timescale 1ns/1ps
module wr_coalesce_buf_bench;
  localparam int TAG_W = 26;
  localparam int WA_W  = 29;
  localparam logic [TAG_W-1:0] BASE_TAG = 26'h0123400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, mem_ready = 1'b1, flush = 1'b0;
  logic [WA_W-1:0] st_waddr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic st_ready_o, mem_valid_o, empty_o;
  logic [TAG_W-1:0] mem_addr_o;
  logic [511:0] mem_data_o;
  logic [63:0]  mem_mask_o;

  always #2 clk = ~clk;

  wr_coalesce_buf u_wr_coalesce_buf (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_waddr_i(st_waddr),
    .st_data_i(st_data), .st_be_i(st_be), .st_ready_o(st_ready_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .mem_mask_o(mem_mask_o), .flush_i(flush),
    .empty_o(empty_o)
  );

  int n_chk = 0, n_bad = 0;
  bit last_acc, first_acc;
  logic [7:0] ref_mem [512];
  logic [7:0] dut_mem [512];
  logic [TAG_W-1:0] txn_addr_q [$];
  logic [63:0]      txn_mask_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample just after the drive point, then move to the next falling edge
  task automatic tick();
    #0.2;
    last_acc = st_valid && st_ready_o;
    if (last_acc)
      for (int j = 0; j < 8; j++)
        if (st_be[j]) ref_mem[{st_waddr[5:0], 3'(j)}] = st_data[8*j +: 8];
    if (mem_valid_o && mem_ready) begin
      for (int k = 0; k < 64; k++)
        if (mem_mask_o[k]) dut_mem[{mem_addr_o[2:0], 6'(k)}] = mem_data_o[8*k +: 8];
      txn_addr_q.push_back(mem_addr_o);
      txn_mask_q.push_back(mem_mask_o);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    st_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic store(input int line, input int word, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1'b1;
    st_waddr = {BASE_TAG + TAG_W'(line), 3'(word)};
    st_data  = d;
    st_be    = be;
    tick();
    first_acc = last_acc;
    while (!last_acc) begin
      mem_ready = 1'b1;
      tick();
    end
    st_valid = 1'b0;
  endtask

  task automatic drain_all();
    st_valid  = 1'b0;
    flush     = 1'b1;
    mem_ready = 1'b1;
    for (int i = 0; i < 200 && !empty_o; i++) tick();
    tick();
    flush = 1'b0;
  endtask

  function automatic bit line_eq(input int line);
    for (int k = 0; k < 64; k++)
      if (dut_mem[line*64 + k] !== ref_mem[line*64 + k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [63:0] dut_word(input int line, input int word);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = dut_mem[line*64 + word*8 + j];
    return w;
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0;
    for (int i = 0; i < 512; i++) begin ref_mem[i] = 8'h00; dut_mem[i] = 8'h00; end
    void'($urandom(32'h5eed_c0a1));
    repeat (3) @(negedge clk);
    #0.1;
    chk(empty_o == 1'b1, "R1 reset empty", 64'(empty_o), 64'd1);
    chk(mem_valid_o == 1'b0, "R1 reset mem_valid", 64'(mem_valid_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #0.1;
    chk(st_ready_o == 1'b1, "R1 ready after reset", 64'(st_ready_o), 64'd1);

    // full line in eight stores
    mem_ready = 1'b1;
    n0 = txn_addr_q.size();
    for (int w = 0; w < 7; w++) store(0, w, 64'h0101010101010101 * 64'(w + 1), 8'hFF);
    idle(3);
    chk(mem_valid_o == 1'b0 && txn_addr_q.size() == n0, "R8 lone partial held",
        64'(txn_addr_q.size() - n0), 64'd0);
    store(0, 7, 64'h0808080808080808, 8'hFF);
    idle(4);
    chk(txn_addr_q.size() == n0 + 1, "R4 one transaction", 64'(txn_addr_q.size() - n0), 64'd1);
    chk(txn_mask_q[n0] == '1, "R4 full mask", txn_mask_q[n0], '1);
    chk(txn_addr_q[n0] == BASE_TAG, "R11 line tag", 64'(txn_addr_q[n0]), 64'(BASE_TAG));
    chk(line_eq(0), "R11 line 0 image", dut_word(0, 3), 64'h0404040404040404);

    // overwrite within one word
    n0 = txn_addr_q.size();
    store(1, 2, 64'h1111_2222_3333_4444, 8'hFF);
    store(1, 2, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
    drain_all();
    chk(empty_o == 1'b1, "R10 flush empties", 64'(empty_o), 64'd1);
    chk(txn_addr_q.size() == n0 + 1, "R2 merged one txn", 64'(txn_addr_q.size() - n0), 64'd1);
    chk(txn_mask_q[n0] == 64'hFF << 16, "R3 mask OR", txn_mask_q[n0], 64'hFF << 16);
    chk(dut_word(1, 2) == 64'h1111_2222_CCCC_DDDD, "R3 newer bytes win",
        dut_word(1, 2), 64'h1111_2222_CCCC_DDDD);
    chk(line_eq(1), "R11 line 1 image", dut_word(1, 0), 64'd0);

    // blocked downstream port
    n0 = txn_addr_q.size();
    mem_ready = 1'b0;
    for (int l = 2; l < 6; l++) begin
      store(l, 0, 64'h0 + 64'(l) * 64'h1000_0001, 8'hFF);
      chk(first_acc, "R12 accepted while blocked", 64'(first_acc), 64'd1);
    end
    chk(empty_o == 1'b0, "R1 not empty", 64'(empty_o), 64'd0);
    store(4, 1, 64'hCAFE_F00D_1234_5678, 8'hFF);
    chk(first_acc, "R2 merge while full", 64'(first_acc), 64'd1);
    st_valid = 1'b1;
    st_waddr = {BASE_TAG + TAG_W'(2), 3'd3};
    st_data  = 64'hDEAD_DEAD_DEAD_DEAD;
    st_be    = 8'hFF;
    tick();
    chk(!last_acc, "R9 no merge into draining head", 64'(last_acc), 64'd0);
    tick();
    chk(mem_valid_o && mem_addr_o == BASE_TAG + TAG_W'(2), "R9 head held",
        64'(mem_addr_o), 64'(BASE_TAG + TAG_W'(2)));
    st_waddr = {BASE_TAG + TAG_W'(6), 3'd5};
    st_data  = 64'h6666_7777_8888_9999;
    tick();
    chk(!last_acc, "R5 stall when full", 64'(last_acc), 64'd0);
    mem_ready = 1'b1;
    #0.1;
    chk(st_ready_o == 1'b1, "R6 same-cycle slot reuse", 64'(st_ready_o), 64'd1);
    tick();
    chk(last_acc, "R6 store taken", 64'(last_acc), 64'd1);
    drain_all();
    chk(txn_addr_q.size() == n0 + 5, "R7 txn count", 64'(txn_addr_q.size() - n0), 64'd5);
    for (int i = 0; i < 5 && n0 + i < txn_addr_q.size(); i++)
      chk(txn_addr_q[n0 + i] == BASE_TAG + TAG_W'(2 + i), "R7 oldest first",
          64'(txn_addr_q[n0 + i]), 64'(BASE_TAG + TAG_W'(2 + i)));
    if (txn_mask_q.size() > n0 + 2)
      chk(txn_mask_q[n0 + 2] == 64'hFFFF, "R2 merged mask", txn_mask_q[n0 + 2], 64'hFFFF);

    // store to the line under drain
    n0 = txn_addr_q.size();
    mem_ready = 1'b0;
    store(0, 0, 64'h0A0A_0A0A_0A0A_0A0A, 8'hFF);
    store(1, 0, 64'h0B0B_0B0B_0B0B_0B0B, 8'hFF);
    idle(2);
    #0.1;
    chk(mem_valid_o && mem_addr_o == BASE_TAG, "R8 drain starts with two entries",
        64'(mem_addr_o), 64'(BASE_TAG));
    store(0, 1, 64'h0C0C_0C0C_0C0C_0C0C, 8'hFF);
    chk(first_acc, "R9 new entry for frozen line", 64'(first_acc), 64'd1);
    drain_all();
    chk(txn_addr_q.size() == n0 + 3, "R9 three txns", 64'(txn_addr_q.size() - n0), 64'd3);
    if (txn_mask_q.size() >= n0 + 3) begin
      chk(txn_mask_q[n0] == 64'hFF, "R9 frozen mask", txn_mask_q[n0], 64'hFF);
      chk(txn_addr_q[n0 + 2] == BASE_TAG && txn_mask_q[n0 + 2] == 64'hFF00,
          "R7 late entry last", txn_mask_q[n0 + 2], 64'hFF00);
    end

    // random traffic
    for (int it = 0; it < 1500; it++) begin
      mem_ready = ($urandom % 10) < 7;
      flush     = ($urandom % 20) == 0;
      if (($urandom % 10) < 7) begin
        logic [7:0] be;
        be = 8'($urandom);
        if (be == 8'h00) be = 8'h01;
        store(int'($urandom % 8), int'($urandom % 8), {$urandom, $urandom}, be);
      end else idle(1);
    end
    drain_all();
    chk(empty_o == 1'b1, "R10 final empty", 64'(empty_o), 64'd1);
    for (int l = 0; l < 8; l++)
      chk(line_eq(l), "R3 R7 random image", dut_word(l, 0), {ref_mem[l*64+7], ref_mem[l*64+6],
          ref_mem[l*64+5], ref_mem[l*64+4], ref_mem[l*64+3], ref_mem[l*64+2],
          ref_mem[l*64+1], ref_mem[l*64]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule